// File: doc/BRIEF.md
# Match/Capture Counter-Timer with PWM

This block is a general-purpose timer for a larger chip. A wide up-counter advances on ticks that come from a programmable prescaler. The prescaler counts either every system clock or selected edges of an external capture signal, which first passes through a two-flop synchroniser. Several match registers are compared against the count. When one of them is equal on a tick, that channel can flag an interrupt, return the counter to zero, halt the counter, and act on its external match pin. One capture channel copies the count into a capture register on a chosen edge of the synchronised input.

Software reaches the block through a word-addressed write/read port. Writes are single-cycle strobes. Reads are combinational on the address. The three lowest match channels can each be switched to single-edge PWM. In that mode the highest match channel, with reset-on-match set, fixes the cycle length.

Counting is governed by a three-state controller. In IDLE the counter holds. RUN is entered from IDLE when the enable bit is set (`go`). RUN returns to IDLE when the enable bit is cleared or when a stop-on-match fires (`halt`). CLEAR is entered from either state while the clear bit is set (`wipe`), and it zeroes the count and the prescale count. CLEAR returns to IDLE when the clear bit drops (`release`).

Top module: `mct_timer`

## Requirements
- R1: With the count source on the system clock (word 1 = 0) and prescale limit P in word 2, the count (read at word 3) rises by one every P+1 clocks while running. The prescale count (word 4) cycles from 0 to P. Counting starts in the second clock after word 0 bit 0 (enable) is written 1.
- R2: A channel i (match value at word 12+i) whose stop bit (word 5 bit 3i+2) is set halts the counter on a tick where the count equals its value. The count then holds that value, the enable bit reads 0, and the prescale count reads 0.
- R3: A channel whose reset bit (word 5 bit 3i+1) is set sends the count to 0 on the tick where the count equals its value, so the count never exceeds that value. With reset and stop both set, the count ends at 0 and halts.
- R4: Status word 10 holds sticky flags: bit i for a match hit on channel i, bit 4 for a capture. Writing 1 to a bit clears it, and writing 0 leaves it. `irq` is the OR of the set flags whose enables are set (word 5 bit 3i for match i, word 6 bit 2 for capture).
- R5: Word 8 bits [3:0] write the match pin states directly. Bits [5+2i:4+2i] pick channel i's action on a hit: 0 leave, 1 low, 2 high, 3 toggle.
- R6: When PWM is enabled for channel i<3 (word 9 bit i), its pin is low while the count is below its match value and high from that value onward. A match value of 0 gives a pin high for the whole cycle.
- R7: The capture register (word 7) loads the count on a rising edge of the synchronised input if word 6 bit 0 is set, or on a falling edge if bit 1 is set. An edge that is not selected changes neither the capture register nor flag 4.
- R8: Word 1 values 1, 2 and 3 make the count source rising edges, falling edges, or both edges of the synchronised capture input.
- R9: After reset the count, the prescale count, the flags, the match pins, `irq` and word 0 all read 0.
- R10: Holding word 0 bit 1 (clear) forces the count and the prescale count to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register word address |
| wdata | input | CW | Write data |
| rdata | output | CW | Read data for `addr` |
| cap_in | input | 1 | Asynchronous capture / count input |
| match_out | output | NM | Match and PWM pins |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 32-bit count, four match channels, an 8-bit prescaler and a two-stage synchroniser. Small match values and a prescale limit of 2 keep every scenario within a few dozen clocks. They still exercise the divider, wrap-around at a period match, a halt that lands on a match, and a full PWM cycle. Four channels are the smallest set that lets three PWM or action channels run against a separate period channel.

// File: rtl/mct_pkg.sv
package mct_pkg;
    localparam int ADDR_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_CLEAR = 2'd2
    } run_state_e;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_LOW    = 2'd1,
        ACT_HIGH   = 2'd2,
        ACT_TOGGLE = 2'd3
    } pin_act_e;

    typedef enum logic [1:0] {
        SRC_CLK  = 2'd0,
        SRC_RISE = 2'd1,
        SRC_FALL = 2'd2,
        SRC_BOTH = 2'd3
    } cnt_src_e;

    localparam logic [ADDR_W-1:0] W_CTRL  = 4'd0;
    localparam logic [ADDR_W-1:0] W_SRC   = 4'd1;
    localparam logic [ADDR_W-1:0] W_PRE   = 4'd2;
    localparam logic [ADDR_W-1:0] W_CNT   = 4'd3;
    localparam logic [ADDR_W-1:0] W_PCNT  = 4'd4;
    localparam logic [ADDR_W-1:0] W_MCFG  = 4'd5;
    localparam logic [ADDR_W-1:0] W_CCFG  = 4'd6;
    localparam logic [ADDR_W-1:0] W_CAP   = 4'd7;
    localparam logic [ADDR_W-1:0] W_PINS  = 4'd8;
    localparam logic [ADDR_W-1:0] W_PWM   = 4'd9;
    localparam logic [ADDR_W-1:0] W_FLAG  = 4'd10;
    localparam logic [ADDR_W-1:0] W_MBASE = 4'd12;
endpackage

// File: rtl/mct_sync.sv
module mct_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;
    logic              lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            prev  <= chain[STAGES-1];
        end
    end

    assign lvl  = chain[STAGES-1];
    assign rise = lvl & ~prev;
    assign fall = ~lvl & prev;

    // R7: an edge pulse never lasts two cycles
    p_edge_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rise || fall) |=> !(rise && $past(rise)) && !(fall && $past(fall)));
endmodule

// File: rtl/mct_fsm.sv
module mct_fsm
    import mct_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr_req,
    input  logic stop_hit,
    output logic run,
    output logic clear
);
    run_state_e st, st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: begin
                if (clr_req)  st_nx = ST_CLEAR;
                else if (en)  st_nx = ST_RUN;
            end
            ST_RUN: begin
                if (clr_req)                st_nx = ST_CLEAR;
                else if (!en || stop_hit)   st_nx = ST_IDLE;
            end
            ST_CLEAR: begin
                if (!clr_req) st_nx = ST_IDLE;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        run   = (st == ST_RUN);
        clear = (st == ST_CLEAR);
    end

    // R2: a stop hit takes the controller out of RUN on the next edge
    p_halt_leaves_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && stop_hit) |=> !run);
    // R10: CLEAR is only ever entered while the clear bit is held
    p_wipe_needs_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clear) |-> $past(clr_req));
endmodule

// File: rtl/mct_match.sv
module mct_match
    import mct_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] mval,
    input  logic          tick,
    input  pin_act_e      act,
    input  logic          pwm_mode,
    input  logic          pin_wr,
    input  logic          pin_wval,
    output logic          hit,
    output logic          pin
);
    logic pin_q;

    assign hit = tick && (cnt == mval);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q <= 1'b0;
        end else if (pin_wr) begin
            pin_q <= pin_wval;
        end else if (hit) begin
            unique case (act)
                ACT_NONE:   pin_q <= pin_q;
                ACT_LOW:    pin_q <= 1'b0;
                ACT_HIGH:   pin_q <= 1'b1;
                ACT_TOGGLE: pin_q <= ~pin_q;
                default:    pin_q <= pin_q;
            endcase
        end
    end

    assign pin = pwm_mode ? (cnt >= mval) : pin_q;

    // R5: a toggle hit flips the stored pin state
    p_toggle_flips_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && act == ACT_TOGGLE && !pin_wr) |=> pin_q != $past(pin_q));
    // R5: without a hit or a direct write the pin state holds
    p_pin_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && !pin_wr) |=> $stable(pin_q));
endmodule

// File: rtl/mct_timer.sv
module mct_timer
    import mct_pkg::*;
#(
    parameter int CW       = 32,
    parameter int NM       = 4,
    parameter int PW       = 8,
    parameter int SYNC_LEN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CW-1:0]     wdata,
    output logic [CW-1:0]     rdata,
    input  logic              cap_in,
    output logic [NM-1:0]     match_out,
    output logic              irq
);
    localparam int NPWM = NM - 1;
    localparam int MCFG_W = 3 * NM;
    localparam int NFLAG = NM + 1;

    logic              ctrl_en, ctrl_clr;
    cnt_src_e          src_sel;
    logic [PW-1:0]     pre_lim;
    logic [MCFG_W-1:0] mcfg;
    logic [2:0]        ccfg;
    logic [NPWM-1:0]   pwm_en;
    logic [2*NM-1:0]   pin_act;
    logic [CW-1:0]     mreg [NM];
    logic [CW-1:0]     cnt, cap_val;
    logic [PW-1:0]     pcnt;
    logic [NFLAG-1:0]  flags, flag_ien;
    logic [NM-1:0]     hit, m_ie, m_rst, m_stop;
    logic              run, clear, edge_r, edge_f, cnt_evt, pre_done, tick;
    logic              any_rst, any_stop, cap_evt, reg_wr, pins_wr, flag_wr;

    assign reg_wr  = wr_en;
    assign pins_wr = wr_en && (addr == W_PINS);
    assign flag_wr = wr_en && (addr == W_FLAG);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_en  <= 1'b0;
            ctrl_clr <= 1'b0;
            src_sel  <= SRC_CLK;
            pre_lim  <= '0;
            mcfg     <= '0;
            ccfg     <= '0;
            pwm_en   <= '0;
            pin_act  <= '0;
            for (int i = 0; i < NM; i++) mreg[i] <= '0;
        end else begin
            if (reg_wr) begin
                unique case (addr)
                    W_CTRL: begin
                        ctrl_en  <= wdata[0];
                        ctrl_clr <= wdata[1];
                    end
                    W_SRC:  src_sel <= cnt_src_e'(wdata[1:0]);
                    W_PRE:  pre_lim <= wdata[PW-1:0];
                    W_MCFG: mcfg    <= wdata[MCFG_W-1:0];
                    W_CCFG: ccfg    <= wdata[2:0];
                    W_PINS: pin_act <= wdata[NM +: 2*NM];
                    W_PWM:  pwm_en  <= wdata[NPWM-1:0];
                    default: ;
                endcase
            end
            for (int i = 0; i < NM; i++) begin
                if (reg_wr && addr == W_MBASE + ADDR_W'(i)) mreg[i] <= wdata;
            end
            if (any_stop) ctrl_en <= 1'b0;
        end
    end

    for (genvar i = 0; i < NM; i++) begin : g_cfg
        assign m_ie[i]   = mcfg[3*i];
        assign m_rst[i]  = mcfg[3*i+1];
        assign m_stop[i] = mcfg[3*i+2];
    end

    mct_sync #(.STAGES(SYNC_LEN)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (cap_in),
        .rise (edge_r),
        .fall (edge_f)
    );

    always_comb begin
        unique case (src_sel)
            SRC_CLK:  cnt_evt = 1'b1;
            SRC_RISE: cnt_evt = edge_r;
            SRC_FALL: cnt_evt = edge_f;
            SRC_BOTH: cnt_evt = edge_r | edge_f;
            default:  cnt_evt = 1'b0;
        endcase
    end

    assign pre_done = (pcnt == pre_lim);
    assign tick     = run && cnt_evt && pre_done;
    assign any_rst  = |(hit & m_rst);
    assign any_stop = |(hit & m_stop);

    mct_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (ctrl_en),
        .clr_req (ctrl_clr),
        .stop_hit(any_stop),
        .run     (run),
        .clear   (clear)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            pcnt <= '0;
        end else if (clear) begin
            cnt  <= '0;
            pcnt <= '0;
        end else if (run && cnt_evt) begin
            if (pre_done) begin
                pcnt <= '0;
                if (any_rst)       cnt <= '0;
                else if (!any_stop) cnt <= cnt + 1'b1;
            end else begin
                pcnt <= pcnt + 1'b1;
            end
        end
    end

    for (genvar i = 0; i < NM; i++) begin : g_ch
        logic pwm_sel;
        if (i < NPWM) begin : g_pwm
            assign pwm_sel = pwm_en[i];
        end else begin : g_per
            assign pwm_sel = 1'b0;
        end
        mct_match #(.CW(CW)) u_match (
            .clk     (clk),
            .rst_n   (rst_n),
            .cnt     (cnt),
            .mval    (mreg[i]),
            .tick    (tick),
            .act     (pin_act_e'(pin_act[2*i +: 2])),
            .pwm_mode(pwm_sel),
            .pin_wr  (pins_wr),
            .pin_wval(wdata[i]),
            .hit     (hit[i]),
            .pin     (match_out[i])
        );
    end

    assign cap_evt = (edge_r && ccfg[0]) || (edge_f && ccfg[1]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_val <= '0;
        else if (cap_evt) cap_val <= cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags <= '0;
        else flags <= (flags & ~(flag_wr ? wdata[NFLAG-1:0] : '0)) | {cap_evt, hit};
    end

    assign flag_ien = {ccfg[2], m_ie};
    assign irq      = |(flags & flag_ien);

    always_comb begin
        rdata = '0;
        unique case (addr)
            W_CTRL: rdata[1:0]         = {ctrl_clr, ctrl_en};
            W_SRC:  rdata[1:0]         = src_sel;
            W_PRE:  rdata[PW-1:0]      = pre_lim;
            W_CNT:  rdata              = cnt;
            W_PCNT: rdata[PW-1:0]      = pcnt;
            W_MCFG: rdata[MCFG_W-1:0]  = mcfg;
            W_CCFG: rdata[2:0]         = ccfg;
            W_CAP:  rdata              = cap_val;
            W_PINS: rdata[3*NM-1:0]    = {pin_act, match_out};
            W_PWM:  rdata[NPWM-1:0]    = pwm_en;
            W_FLAG: rdata[NFLAG-1:0]   = flags;
            default: ;
        endcase
        for (int i = 0; i < NM; i++) begin
            if (addr == W_MBASE + ADDR_W'(i)) rdata = mreg[i];
        end
    end

    // R1: an ordinary tick advances the count by one
    p_tick_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && tick && !any_rst && !any_stop) |=> cnt == $past(cnt) + 1'b1);
    // R2: a stop hit drops the enable bit
    p_stop_drops_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
        any_stop |=> !ctrl_en);
    // R3: a reset hit returns the count to zero
    p_reset_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        any_rst |=> cnt == '0);
    // R4: a set flag survives unless its clear bit is written
    p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[0] && !(flag_wr && wdata[0])) |=> flags[0]);
    // R7: a capture event stores the count seen at that edge
    p_cap_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> cap_val == $past(cnt));
    // R10: CLEAR leaves both counters at zero
    p_clear_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt == '0) && (pcnt == '0));
endmodule

// File: tb/tb_mct_timer.sv
module tb_mct_timer;
    localparam logic [3:0] A_CTRL = 4'd0, A_SRC = 4'd1, A_PRE = 4'd2, A_CNT = 4'd3,
                           A_PCNT = 4'd4, A_MCFG = 4'd5, A_CCFG = 4'd6, A_CAP = 4'd7,
                           A_PINS = 4'd8, A_PWM = 4'd9, A_FLAG = 4'd10, A_M0 = 4'd12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        cap_in = 1'b0;
    logic [3:0]  match_out;
    logic        irq;
    int          checks = 0;
    int          errors = 0;

    mct_timer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .cap_in(cap_in), .match_out(match_out), .irq(irq)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic wipe();
        wr(A_CTRL, 32'h2);
        repeat (3) @(posedge clk);
        wr(A_CTRL, 32'h0);
        wr(A_FLAG, 32'h1F);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        @(negedge clk);
        rd(A_CNT, v);  chk(v == 0, "R9", "count", v, 0);
        rd(A_PCNT, v); chk(v == 0, "R9", "prescale count", v, 0);
        rd(A_FLAG, v); chk(v == 0, "R9", "flags", v, 0);
        rd(A_CTRL, v); chk(v == 0, "R9", "ctrl", v, 0);
        chk(match_out == 0 && irq == 0, "R9", "pins/irq", {match_out, irq}, 0);
    endtask

    task automatic t_prescale_stop();
        logic [31:0] v;
        wr(A_PRE, 2);
        wr(A_M0, 5);
        wr(A_MCFG, 32'h4);
        wr(A_CTRL, 32'h1);
        repeat (8) @(posedge clk);
        @(negedge clk);
        rd(A_CNT, v);  chk(v == 2, "R1", "count after 8 clocks", v, 2);
        rd(A_PCNT, v); chk(v == 1, "R1", "prescale count", v, 1);
        repeat (30) @(posedge clk);
        @(negedge clk);
        rd(A_CNT, v);  chk(v == 5, "R2", "halted count", v, 5);
        rd(A_PCNT, v); chk(v == 0, "R2", "halted prescale", v, 0);
        rd(A_CTRL, v); chk(v[0] == 0, "R2", "enable bit", v[0], 0);
        rd(A_FLAG, v); chk(v[0] == 1, "R4", "match0 flag", v[0], 1);
        chk(irq == 0, "R4", "irq with enable off", irq, 0);
        wr(A_CTRL, 32'h2);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rd(A_CNT, v);  chk(v == 0, "R10", "count under clear", v, 0);
        wr(A_CTRL, 32'h0);
        wr(A_FLAG, 32'h1F);
    endtask

    task automatic t_reset_match();
        logic [31:0] v;
        bit over = 0, seen = 0;
        wipe();
        wr(A_PRE, 0);
        wr(A_M0 + 1, 3);
        wr(A_MCFG, 32'h18);
        wr(A_CTRL, 32'h1);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            rd(A_CNT, v);
            if (v > 3) over = 1;
            if (v == 3) seen = 1;
        end
        chk(!over && seen, "R3", "count bounded by 3", over, 0);
        chk(irq == 1, "R4", "irq from match1", irq, 1);
        wr(A_CTRL, 32'h0);
        repeat (3) @(posedge clk);
        wr(A_MCFG, 32'h10);
        @(negedge clk);
        chk(irq == 0, "R4", "irq masked", irq, 0);
        wr(A_MCFG, 32'h18);
        @(negedge clk);
        chk(irq == 1, "R4", "irq unmasked", irq, 1);
        wr(A_FLAG, 32'h2);
        @(negedge clk);
        rd(A_FLAG, v); chk(v[1] == 0, "R4", "flag1 after W1C", v[1], 0);
        chk(irq == 0, "R4", "irq after W1C", irq, 0);
    endtask

    task automatic t_pin_actions();
        logic [31:0] v;
        wipe();
        wr(A_MCFG, 32'h0);
        wr(A_M0, 2); wr(A_M0 + 1, 4); wr(A_M0 + 2, 6); wr(A_M0 + 3, 9);
        wr(A_PINS, 32'h1BC);
        @(negedge clk);
        chk(match_out == 4'b1100, "R5", "direct pin write", match_out, 4'b1100);
        wr(A_MCFG, 32'hC00);
        wr(A_CTRL, 32'h1);
        repeat (30) @(posedge clk);
        @(negedge clk);
        chk(match_out == 4'b1011, "R5", "pins after one cycle", match_out, 4'b1011);
        rd(A_CNT, v);  chk(v == 0, "R3", "reset+stop count", v, 0);
        rd(A_CTRL, v); chk(v[0] == 0, "R3", "reset+stop enable", v[0], 0);
    endtask

    task automatic t_pwm();
        logic [31:0] v;
        logic [3:0] exp;
        int bad = 0;
        logic [3:0] last_got = 0, last_exp = 0;
        wipe();
        wr(A_PINS, 32'h4);
        wr(A_M0, 0); wr(A_M0 + 1, 3); wr(A_M0 + 3, 7);
        wr(A_MCFG, 32'h400);
        wr(A_PWM, 32'h3);
        wr(A_CTRL, 32'h1);
        for (int k = 0; k < 24; k++) begin
            @(negedge clk);
            rd(A_CNT, v);
            exp = {1'b0, 1'b1, (v >= 3), 1'b1};
            if (match_out != exp || v > 7) begin
                bad++; last_got = match_out; last_exp = exp;
            end
        end
        chk(bad == 0, "R6", "pwm waveform", last_got, last_exp);
        wr(A_CTRL, 32'h0);
        wr(A_PWM, 32'h0);
    endtask

    task automatic t_capture();
        logic [31:0] v;
        wipe();
        wr(A_M0, 5);
        wr(A_MCFG, 32'h4);
        wr(A_CTRL, 32'h1);
        repeat (20) @(posedge clk);
        wr(A_CCFG, 32'h5);
        wr(A_FLAG, 32'h1F);
        @(negedge clk); cap_in = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rd(A_CAP, v);  chk(v == 5, "R7", "captured count", v, 5);
        rd(A_FLAG, v); chk(v[4] == 1, "R7", "capture flag", v[4], 1);
        chk(irq == 1, "R4", "capture irq", irq, 1);
        wr(A_FLAG, 32'h10);
        @(negedge clk); cap_in = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rd(A_FLAG, v); chk(v[4] == 0, "R7", "unselected fall ignored", v[4], 0);
        wr(A_CCFG, 32'h2);
        @(negedge clk); cap_in = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rd(A_FLAG, v); chk(v[4] == 0, "R7", "unselected rise ignored", v[4], 0);
        cap_in = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rd(A_FLAG, v); chk(v[4] == 1, "R7", "selected fall taken", v[4], 1);
    endtask

    task automatic pulses(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); cap_in = 1'b1;
            repeat (3) @(posedge clk);
            @(negedge clk); cap_in = 1'b0;
            repeat (3) @(posedge clk);
        end
        repeat (5) @(posedge clk);
    endtask

    task automatic t_count_mode();
        logic [31:0] v;
        wipe();
        wr(A_MCFG, 32'h0);
        wr(A_PRE, 0);
        wr(A_SRC, 1);
        wr(A_CTRL, 32'h1);
        pulses(3);
        @(negedge clk);
        rd(A_CNT, v); chk(v == 3, "R8", "rising-edge count", v, 3);
        wr(A_CTRL, 32'h0);
        wipe();
        wr(A_SRC, 3);
        wr(A_CTRL, 32'h1);
        pulses(2);
        @(negedge clk);
        rd(A_CNT, v); chk(v == 4, "R8", "both-edge count", v, 4);
        wr(A_CTRL, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_prescale_stop();
        t_reset_match();
        t_pin_actions();
        t_pwm();
        t_capture();
        t_count_mode();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule